// File: doc/BRIEF.md
# Half-Rate Sync Divider

This block conditions a horizontal sync input for one output pin. In divide mode the output toggles on every rising edge of the sampled input, so it runs at half the input rate with an even duty cycle. In pass-through mode the output follows the sampled input, and a polarity bit chooses whether it is inverted.

Three control bits set the mode: an active-low enable, an active-low pass-through select and a polarity bit. All three are loaded together on a write strobe. When the enable is high, the output-enable line is low and the pin is released for general-purpose use. The input is sampled through a synchronizer chain of `SYNC_STAGES` flops. The divider flop is held at zero while the block is disabled, so every enable starts from a known phase.

Top module: `half_rate_sync_div`

## Requirements
- R1: A write with `cfg_en_n`=0 raises `sync_oe` one edge later. A write with `cfg_en_n`=1 drops `sync_oe` and forces `sync_out` to 0 one edge later.
- R2: In divide mode (`cfg_en_n`=0, `cfg_byp_n`=1), each rising edge of `sync_in` toggles `sync_out` exactly `SYNC_STAGES`+1 clock edges after the edge at which the new level is first sampled. The output therefore runs at half the input rate with a 50% duty cycle.
- R3: In pass-through mode (`cfg_en_n`=0, `cfg_byp_n`=0) with `cfg_pol`=1, `sync_out` equals `sync_in` delayed by `SYNC_STAGES` clock edges.
- R4: In pass-through mode with `cfg_pol`=0, `sync_out` is the inverse of `sync_in` delayed by `SYNC_STAGES` clock edges.
- R5: After reset, all three control bits read as 1. In this state `sync_oe`=0 and `sync_out`=0.
- R6: While disabled, the divider is held at 0. After a re-enable, `sync_out` starts at 0 and the first sampled rising edge drives it to 1.
- R7: In divide mode, the value of `cfg_pol` has no effect on `sync_out`.
- R8: In divide mode, a falling edge of `sync_in` leaves `sync_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads the three control bits |
| cfg_en_n | input | 1 | Active-low output enable |
| cfg_byp_n | input | 1 | Active-low pass-through select (0 = copy input, 1 = divide by two) |
| cfg_pol | input | 1 | Pass-through polarity (1 = positive, 0 = inverted) |
| sync_in | input | 1 | Asynchronous sync input |
| sync_out | output | 1 | Divided or copied sync output |
| sync_oe | output | 1 | High when the block drives the pin |

## Verification
A control write takes effect one edge after the strobe. A pass-through output follows its input `SYNC_STAGES` edges after the input is driven. A divider toggle lands one edge later than that.

The bench drives every input half a period away from the active edge and samples shortly after the edge where each result is due. For divider edges, it also checks one edge earlier to confirm the output has not yet moved. Duty cycle is measured by counting high samples over a window that spans exactly two output periods.

// File: rtl/half_rate_sync_div.sv
module half_rate_sync_div #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_en_n,
  input  logic cfg_byp_n,
  input  logic cfg_pol,
  input  logic sync_in,
  output logic sync_out,
  output logic sync_oe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] smp;
  logic          smp_d;
  logic          en_n_q, byp_n_q, pol_q, div_q;

  wire s_now = smp[LAST];
  wire rise  = s_now & ~smp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_q  <= 1'b1;
      byp_n_q <= 1'b1;
      pol_q   <= 1'b1;
    end else if (cfg_wr) begin
      en_n_q  <= cfg_en_n;
      byp_n_q <= cfg_byp_n;
      pol_q   <= cfg_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp   <= '0;
      smp_d <= 1'b0;
    end else begin
      smp   <= {smp[LAST-1:0], sync_in};
      smp_d <= s_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= 1'b0;
    else if (en_n_q) div_q <= 1'b0;
    else if (rise)   div_q <= ~div_q;
  end

  assign sync_oe  = ~en_n_q;
  assign sync_out = en_n_q ? 1'b0 : (byp_n_q ? div_q : (s_now ~^ pol_q));

  AST_RST_DEFAULTS: assert property (@(posedge clk)
    $rose(rst_n) |-> (en_n_q && byp_n_q && pol_q && !sync_oe && !sync_out)); // R5
  AST_OE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_en_n) |=> sync_oe); // R1
  AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en_n) |=> (!sync_oe && !sync_out)); // R1
  AST_DIV_HOLDS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_q && !rise) |=> $stable(div_q)); // R8
  AST_DIV_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_q |=> !div_q); // R6
endmodule

// File: tb/half_rate_sync_div_bench.sv
module half_rate_sync_div_bench;
  localparam int CLK_P = 10;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en_n = 1'b1, cfg_byp_n = 1'b1, cfg_pol = 1'b1;
  logic sync_in = 1'b0;
  logic sync_out, sync_oe;
  int   n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  half_rate_sync_div #(.SYNC_STAGES(NS)) u_half_rate_sync_div (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en_n(cfg_en_n),
    .cfg_byp_n(cfg_byp_n), .cfg_pol(cfg_pol), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe));

  // {en_n, byp_n, pol, in, exp_oe, exp_out}
  localparam logic [5:0] VEC [8] = '{
    6'b1_1_1_1_0_0, // R1 disabled
    6'b0_0_1_0_1_0, // R3
    6'b0_0_1_1_1_1, // R3
    6'b0_0_0_0_1_1, // R4
    6'b0_0_0_1_1_0, // R4
    6'b1_0_1_1_0_0, // R1
    6'b0_0_1_1_1_1, // R3
    6'b0_0_0_1_1_0  // R4
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic en_n, input logic byp_n, input logic pol);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_en_n = en_n; cfg_byp_n = byp_n; cfg_pol = pol;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    sync_in = v;
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R5 oe after reset", sync_oe, 1'b0);
    chk("R5 out after reset", sync_out, 1'b0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][5], VEC[i][4], VEC[i][3]);
      drive(VEC[i][2]);
      tick(NS + 1);
      chk($sformatf("R1 oe vec%0d", i), sync_oe, VEC[i][1]);
      chk($sformatf("R3/R4 out vec%0d", i), sync_out, VEC[i][0]);
    end

    // R3 latency check: change input, observe at NS edges but not NS-1
    wr(1'b0, 1'b0, 1'b1);
    drive(1'b0); tick(NS + 2);
    drive(1'b1); tick(NS - 1);
    chk("R3 not yet", sync_out, 1'b0);
    tick(1);
    chk("R3 at latency", sync_out, 1'b1);

    // R6 restart phase, R2 toggle timing
    drive(1'b0);
    wr(1'b1, 1'b1, 1'b1);
    tick(NS + 2);
    wr(1'b0, 1'b1, 1'b1);
    #1;
    chk("R6 out after re-enable", sync_out, 1'b0);
    chk("R1 oe enabled", sync_oe, 1'b1);
    drive(1'b1); tick(NS);
    chk("R2 no toggle before latency", sync_out, 1'b0);
    tick(1);
    chk("R6 first rise drives 1", sync_out, 1'b1);
    drive(1'b0); tick(NS + 3);
    chk("R8 falling edge ignored", sync_out, 1'b1);
    wr(1'b0, 1'b1, 1'b0);
    #1;
    chk("R7 pol ignored (low)", sync_out, 1'b1);
    wr(1'b0, 1'b1, 1'b1);
    #1;
    chk("R7 pol ignored (high)", sync_out, 1'b1);
    drive(1'b1); tick(NS + 1);
    chk("R2 second rise toggles", sync_out, 1'b0);

    // R6: disable clears divider then re-enable
    drive(1'b0); tick(NS + 1);
    drive(1'b1); tick(NS + 2);
    chk("R2 third rise", sync_out, 1'b1);
    wr(1'b1, 1'b1, 1'b1);
    #1;
    chk("R1 disable releases", sync_oe, 1'b0);
    chk("R1 disable out low", sync_out, 1'b0);
    wr(1'b0, 1'b1, 1'b1);
    #1;
    chk("R6 divider cleared", sync_out, 1'b0);

    // R2 duty cycle over two output periods
    begin
      int highs = 0;
      for (int i = 0; i < 56; i++) begin
        @(negedge clk);
        sync_in = ((i / 4) % 2) == 1;
        @(posedge clk); #1;
        if (i >= 24 && sync_out) highs++;
      end
      n_run++;
      if (highs != 16) begin
        n_fail++;
        $display("FAIL R2 duty actual=%0d expected=16", highs);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule